// File: doc/BRIEF.md
# Free-Running Compare/Capture Timer

This block is a timer built around a free-running up-counter. A prescaler steps the counter once every 1, 4, 8 or 16 clocks. Several output-compare channels watch the counter. On a match, each one sets its flag and applies a programmed action to its own output pin. A master compare channel can, on its own match, force any chosen set of those pins to preset levels. Input-capture channels detect chosen edges on their pins and copy the counter value into a capture register. A rollover flag marks the wrap from all ones to zero.

Software reaches the block through a simple register port: a write strobe with address and data, and a combinational read of the addressed register. Every event has a flag, and every flag has an enable bit. The interrupt output is the OR of the enabled flags. Flags are cleared by writing ones to them. The prescaler choice is guarded. In normal operation it can be written once, and only during a short window after reset. With the unlock input high it can be changed at any time.

There is no streaming data path. All pins are plain level signals with no handshake.

Register map (5-bit address): 0x00 counter (read-only), 0x01 prescaler select, 0x02 flags, 0x03 flag enables, 0x04 master pin mask, 0x05 master pin data, 0x06 compare actions (2 bits per channel, channel i at bits 2i+1:2i), 0x07 capture edge codes (same packing), 0x08 master compare value, 0x09+i compare value of channel i, 0x10+j capture value of channel j (read-only). Flag bits: bit 0 rollover, bit 1 master compare, bits 2..2+NOC-1 compare channels, then the capture channels.

Top module: `tmr_core`

## Requirements
- R1: While reset is asserted, the counter reads 0, every compare value reads 0xFFFF, the flags read 0, all compare pins are 0, the interrupt output is 0 and the prescaler select reads 0.
- R2: The counter increments by one every N clocks. N is 1, 4, 8 or 16 for select codes 0, 1, 2 and 3.
- R3: With unlock low, a prescaler-select write takes effect only if it is the first such write and it falls within the first 64 clocks after reset. Every other write leaves the select unchanged. With unlock high, every write takes effect.
- R4: The rollover flag (flag bit 0) is set when the counter steps from 0xFFFF to 0x0000.
- R5: A compare channel's flag is set on the clock edge after the counter steps onto that channel's compare value. Reset itself does not count as a step.
- R6: On a compare match, channel i's pin follows its 2-bit action code at the same edge as the flag: 00 leaves the pin unchanged, 01 inverts it, 10 drives it to 0, 11 drives it to 1.
- R7: On a master compare match, every pin whose mask bit is 1 takes the matching bit of the master data register. When a channel and the master act on the same pin at the same edge, the master's value wins.
- R8: Capture pins pass through a two-stage synchronizer. Edge code 00 ignores the pin, 01 acts on rising edges, 10 on falling edges and 11 on both. On a selected edge, the capture register takes a stable copy of the counter, equal to its value in the detection cycle, and the capture flag is set.
- R9: Writing the flag register clears each flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged. A flag set by an event at the same edge stays set.
- R10: The interrupt output is high exactly when some flag and its enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| unlock_i | input | 1 | High lifts the write-once guard on the prescaler select |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 5 | Register address |
| bus_wdata_i | input | 16 | Register write data |
| bus_rdata_o | output | 16 | Read data of the addressed register (combinational) |
| oc_pin_o | output | 4 | Compare channel pins |
| ic_pin_i | input | 3 | Capture channel pins (asynchronous) |
| irq_o | output | 1 | Interrupt request |

## Verification
The prescaler is exercised with every select code over a 32-clock window. Each code yields a distinct counter step (32, 8, 4 or 2), so a wrong divider is caught. Compare actions are tried in two rounds: first all channels drive high, then the codes for invert, drive low, drive high and no action are mixed. Each pin's final level therefore tells the four codes apart. A master match is then placed on the same count as a conflicting channel action, which shows whether the master wins. Capture pins are raised and then lowered with rising, falling and both-edge codes, and the latched counter is compared with the count read in the detection cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_LOW    = 2'b10,
    ACT_HIGH   = 2'b11
  } oc_act_e;

  localparam int A_COUNT  = 'h00;
  localparam int A_CTRL   = 'h01;
  localparam int A_FLAG   = 'h02;
  localparam int A_IEN    = 'h03;
  localparam int A_MMASK  = 'h04;
  localparam int A_MDATA  = 'h05;
  localparam int A_OCMODE = 'h06;
  localparam int A_ICEDGE = 'h07;
  localparam int A_CMP0   = 'h08;
  localparam int A_CAP0   = 'h10;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int CW  = 16,
  parameter int WIN = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          unlock_i,
  input  logic          sel_we_i,
  input  logic [1:0]    sel_wd_i,
  output logic [1:0]    sel_o,
  output logic [CW-1:0] cnt_o,
  output logic          upd_o,
  output logic          wrap_o
);
  localparam int AGW = $clog2(WIN + 1);

  logic [3:0]     pre_q;
  logic [3:0]     pre_mask;
  logic [1:0]     sel_q;
  logic           lock_q;
  logic [AGW-1:0] age_q;
  logic [CW-1:0]  cnt_q;
  logic           upd_q;
  logic           tick;
  logic           sel_ok;

  always_comb begin
    unique case (sel_q)
      2'd0:    pre_mask = 4'h0;
      2'd1:    pre_mask = 4'h3;
      2'd2:    pre_mask = 4'h7;
      default: pre_mask = 4'hF;
    endcase
  end

  assign tick   = (pre_q & pre_mask) == pre_mask;
  assign sel_ok = unlock_i || (!lock_q && (age_q < AGW'(WIN)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      sel_q  <= '0;
      lock_q <= 1'b0;
      age_q  <= '0;
      cnt_q  <= '0;
      upd_q  <= 1'b0;
    end else begin
      pre_q <= pre_q + 4'd1;
      upd_q <= tick;
      if (tick) cnt_q <= cnt_q + CW'(1);
      if (age_q < AGW'(WIN)) age_q <= age_q + AGW'(1);
      if (sel_we_i && sel_ok) begin
        sel_q <= sel_wd_i;
        if (!unlock_i) lock_q <= 1'b1;
      end
    end
  end

  assign sel_o  = sel_q;
  assign cnt_o  = cnt_q;
  assign upd_o  = upd_q;
  assign wrap_o = tick && (&cnt_q);

  AST_SEL_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_we_i && !unlock_i && age_q >= AGW'(WIN)) |=> $stable(sel_o)); // R3

  AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |-> (cnt_o == $past(cnt_o) + CW'(1))); // R2
endmodule

// File: rtl/tmr_compare.sv
module tmr_compare
  import tmr_pkg::*;
#(
  parameter int CW  = 16,
  parameter int NOC = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [CW-1:0]           cnt_i,
  input  logic                    upd_i,
  input  logic [CW-1:0]           cmp_m_i,
  input  logic [NOC-1:0][CW-1:0]  cmp_n_i,
  input  logic [2*NOC-1:0]        mode_i,
  input  logic [NOC-1:0]          mmask_i,
  input  logic [NOC-1:0]          mdata_i,
  output logic [NOC-1:0]          pin_o,
  output logic                    hit_m_o,
  output logic [NOC-1:0]          hit_n_o
);
  logic [NOC-1:0] pin_q;
  logic [NOC-1:0] pin_d;

  assign hit_m_o = upd_i && (cnt_i == cmp_m_i);

  for (genvar i = 0; i < NOC; i++) begin : g_ch
    oc_act_e act;
    assign act        = oc_act_e'(mode_i[2*i +: 2]);
    assign hit_n_o[i] = upd_i && (cnt_i == cmp_n_i[i]);

    always_comb begin
      pin_d[i] = pin_q[i];
      if (hit_n_o[i]) begin
        unique case (act)
          ACT_TOGGLE: pin_d[i] = ~pin_q[i];
          ACT_LOW:    pin_d[i] = 1'b0;
          ACT_HIGH:   pin_d[i] = 1'b1;
          default:    pin_d[i] = pin_q[i];
        endcase
      end
      if (hit_m_o && mmask_i[i]) pin_d[i] = mdata_i[i];
    end

    AST_MASTER_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit_m_o && mmask_i[i]) |=> (pin_o[i] == $past(mdata_i[i]))); // R7

    AST_ACT_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit_n_o[i] && act == ACT_TOGGLE && !(hit_m_o && mmask_i[i]))
        |=> (pin_o[i] != $past(pin_o[i]))); // R6

    AST_ACT_NONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!hit_m_o && act == ACT_NONE) |=> $stable(pin_o[i])); // R6
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= '0;
    else         pin_q <= pin_d;
  end

  assign pin_o = pin_q;
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture #(
  parameter int CW  = 16,
  parameter int NIC = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NIC-1:0]         pin_i,
  input  logic [2*NIC-1:0]       edge_i,
  input  logic [CW-1:0]          cnt_i,
  output logic [NIC-1:0]         hit_o,
  output logic [NIC-1:0][CW-1:0] cap_o
);
  logic [NIC-1:0]         s1_q, s2_q, prev_q;
  logic [CW-1:0]          hold_q;
  logic [NIC-1:0][CW-1:0] cap_q;

  // counter copy taken half a cycle away from the increment edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= '0;
    else         hold_q <= cnt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= pin_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  for (genvar j = 0; j < NIC; j++) begin : g_ch
    logic rise, fall;
    assign rise     = s2_q[j] & ~prev_q[j];
    assign fall     = ~s2_q[j] & prev_q[j];
    assign hit_o[j] = (edge_i[2*j] & rise) | (edge_i[2*j+1] & fall);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       cap_q[j] <= '0;
      else if (hit_o[j]) cap_q[j] <= hold_q;
    end

    AST_CAPTURE_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_o[j] |=> (cap_o[j] == $past(cnt_i))); // R8
  end

  assign cap_o = cap_q;
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int CW  = 16,
  parameter int NOC = 4,
  parameter int NIC = 3,
  parameter int WIN = 64,
  parameter int AW  = 5
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           unlock_i,
  input  logic           bus_we_i,
  input  logic [AW-1:0]  bus_addr_i,
  input  logic [CW-1:0]  bus_wdata_i,
  output logic [CW-1:0]  bus_rdata_o,
  output logic [NOC-1:0] oc_pin_o,
  input  logic [NIC-1:0] ic_pin_i,
  output logic           irq_o
);
  localparam int NF = 2 + NOC + NIC;

  logic [1:0]             sel;
  logic [CW-1:0]          cnt;
  logic                   upd, wrap, hit_m;
  logic [NOC-1:0]         hit_n;
  logic [NIC-1:0]         cap_hit;
  logic [NIC-1:0][CW-1:0] cap;

  logic [NF-1:0]          flag_q, ien_q, flag_set, flag_clr;
  logic [NOC-1:0]         mmask_q, mdata_q;
  logic [2*NOC-1:0]       ocmode_q;
  logic [2*NIC-1:0]       icedge_q;
  logic [CW-1:0]          cmp_m_q;
  logic [NOC-1:0][CW-1:0] cmp_n_q;

  tmr_prescale #(.CW(CW), .WIN(WIN)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .unlock_i(unlock_i),
    .sel_we_i(bus_we_i && bus_addr_i == AW'(A_CTRL)),
    .sel_wd_i(bus_wdata_i[1:0]),
    .sel_o(sel), .cnt_o(cnt), .upd_o(upd), .wrap_o(wrap)
  );

  tmr_compare #(.CW(CW), .NOC(NOC)) u_cmp (
    .clk_i(clk_i), .rst_ni(rst_ni), .cnt_i(cnt), .upd_i(upd),
    .cmp_m_i(cmp_m_q), .cmp_n_i(cmp_n_q), .mode_i(ocmode_q),
    .mmask_i(mmask_q), .mdata_i(mdata_q),
    .pin_o(oc_pin_o), .hit_m_o(hit_m), .hit_n_o(hit_n)
  );

  tmr_capture #(.CW(CW), .NIC(NIC)) u_cap (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(ic_pin_i), .edge_i(icedge_q),
    .cnt_i(cnt), .hit_o(cap_hit), .cap_o(cap)
  );

  assign flag_set = {cap_hit, hit_n, hit_m, wrap};
  assign flag_clr = (bus_we_i && bus_addr_i == AW'(A_FLAG)) ? bus_wdata_i[NF-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q   <= '0;
      ien_q    <= '0;
      mmask_q  <= '0;
      mdata_q  <= '0;
      ocmode_q <= '0;
      icedge_q <= '0;
      cmp_m_q  <= '1;
      cmp_n_q  <= '1;
    end else begin
      flag_q <= (flag_q & ~flag_clr) | flag_set;
      if (bus_we_i) begin
        unique case (bus_addr_i)
          AW'(A_IEN):    ien_q    <= bus_wdata_i[NF-1:0];
          AW'(A_MMASK):  mmask_q  <= bus_wdata_i[NOC-1:0];
          AW'(A_MDATA):  mdata_q  <= bus_wdata_i[NOC-1:0];
          AW'(A_OCMODE): ocmode_q <= bus_wdata_i[2*NOC-1:0];
          AW'(A_ICEDGE): icedge_q <= bus_wdata_i[2*NIC-1:0];
          AW'(A_CMP0):   cmp_m_q  <= bus_wdata_i;
          default: ;
        endcase
        for (int i = 0; i < NOC; i++)
          if (bus_addr_i == AW'(A_CMP0 + 1 + i)) cmp_n_q[i] <= bus_wdata_i;
      end
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      AW'(A_COUNT):  bus_rdata_o = cnt;
      AW'(A_CTRL):   bus_rdata_o = CW'(sel);
      AW'(A_FLAG):   bus_rdata_o = CW'(flag_q);
      AW'(A_IEN):    bus_rdata_o = CW'(ien_q);
      AW'(A_MMASK):  bus_rdata_o = CW'(mmask_q);
      AW'(A_MDATA):  bus_rdata_o = CW'(mdata_q);
      AW'(A_OCMODE): bus_rdata_o = CW'(ocmode_q);
      AW'(A_ICEDGE): bus_rdata_o = CW'(icedge_q);
      AW'(A_CMP0):   bus_rdata_o = cmp_m_q;
      default: ;
    endcase
    for (int i = 0; i < NOC; i++)
      if (bus_addr_i == AW'(A_CMP0 + 1 + i)) bus_rdata_o = cmp_n_q[i];
    for (int j = 0; j < NIC; j++)
      if (bus_addr_i == AW'(A_CAP0 + j)) bus_rdata_o = cap[j];
  end

  assign irq_o = |(flag_q & ien_q);

  AST_WRAP_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap && $past(cnt) != cnt) |=> flag_q[0]); // R4

  AST_FLAG_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|flag_set) |=> ((flag_q & $past(flag_set)) == $past(flag_set))); // R9

  AST_FLAG_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == AW'(A_FLAG)) |=>
      ((flag_q & ~$past(flag_set)) ==
       ($past(flag_q) & ~$past(bus_wdata_i[NF-1:0]) & ~$past(flag_set)))); // R9
endmodule

// File: tb/sim_tmr_core.sv
module sim_tmr_core;
  import tmr_pkg::*;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        unlock = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wd = '0;
  logic [15:0] rdata;
  logic [3:0]  pins;
  logic [2:0]  icp = '0;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // row: [7:6] select code, [5:0] expected counter step over 32 clocks
  localparam logic [7:0] PS_TAB [4] = '{{2'd3, 6'd2}, {2'd2, 6'd4}, {2'd1, 6'd8}, {2'd0, 6'd32}};

  always #(CLK_P/2) clk = ~clk;

  tmr_core u0 (
    .clk_i(clk), .rst_ni(rst_n), .unlock_i(unlock), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wd), .bus_rdata_o(rdata),
    .oc_pin_o(pins), .ic_pin_i(icp), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk);
    we = 1'b1; addr = 5'(a); wd = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [15:0] v);
    @(negedge clk);
    addr = 5'(a);
    #1 v = rdata;
  endtask

  initial begin
    logic [15:0] v, c, c2;
    // R1 reset state, sampled while reset is held
    repeat (2) @(negedge clk);
    rd(A_COUNT, v);    chk("R1 counter", v, 0);
    rd(A_CMP0 + 1, v); chk("R1 compare", v, 16'hFFFF);
    rd(A_FLAG, v);     chk("R1 flags", v, 0);
    rd(A_CTRL, v);     chk("R1 select", v, 0);
    chk("R1 pins", pins, 0);
    chk("R1 irq", irq, 0);
    rst_n = 1'b1;

    // R3 first write inside the window sticks, second is dropped
    wr(A_CTRL, 16'd3);
    wr(A_CTRL, 16'd1);
    rd(A_CTRL, v); chk("R3 second write ignored", v, 3);
    rd(A_COUNT, c);
    repeat (31) @(negedge clk);
    rd(A_COUNT, c2); chk("R2 divide by 16", c2 - c, 2);

    // R3 first write after the window is dropped
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    repeat (70) @(negedge clk);
    wr(A_CTRL, 16'd2);
    rd(A_CTRL, v); chk("R3 late write ignored", v, 0);

    // R2 table of select codes with the guard lifted
    unlock = 1'b1;
    for (int k = 0; k < 4; k++) begin
      wr(A_CTRL, 16'(PS_TAB[k][7:6]));
      rd(A_COUNT, c);
      repeat (31) @(negedge clk);
      rd(A_COUNT, c2);
      chk("R2 prescale step", c2 - c, 32'(PS_TAB[k][5:0]));
    end

    // R5 R6 all channels drive high
    rd(A_COUNT, c);
    wr(A_OCMODE, 16'hFF);
    for (int i = 0; i < 4; i++) wr(A_CMP0 + 1 + i, c + 16'd60);
    repeat (80) @(negedge clk);
    chk("R6 drive high", pins, 4'hF);
    rd(A_FLAG, v); chk("R5 compare flags", v, 16'h003C);

    // R9 write-one-to-clear
    wr(A_FLAG, 16'h0000); rd(A_FLAG, v); chk("R9 zero write keeps", v, 16'h003C);
    wr(A_FLAG, 16'h0004); rd(A_FLAG, v); chk("R9 single clear", v, 16'h0038);
    wr(A_FLAG, 16'h01FF); rd(A_FLAG, v); chk("R9 clear all", v, 0);

    // R6 mixed codes: ch0 invert, ch1 low, ch2 high, ch3 none
    rd(A_COUNT, c);
    wr(A_OCMODE, 16'h0039);
    for (int i = 0; i < 4; i++) wr(A_CMP0 + 1 + i, c + 16'd60);
    repeat (80) @(negedge clk);
    chk("R6 mixed actions", pins, 4'hC);
    wr(A_FLAG, 16'h01FF);

    // R7 master forces ch0=0, ch1=1 and overrides ch0 drive-high
    rd(A_COUNT, c);
    wr(A_MMASK, 16'h0003);
    wr(A_MDATA, 16'h0002);
    wr(A_OCMODE, 16'h002F);
    wr(A_CMP0, c + 16'd60);
    for (int i = 0; i < 3; i++) wr(A_CMP0 + 1 + i, c + 16'd60);
    repeat (80) @(negedge clk);
    chk("R7 master wins", pins, 4'hA);
    rd(A_FLAG, v); chk("R7 master flag", v[1], 1);

    // R10 interrupt follows enabled flags
    wr(A_IEN, 16'h0002); @(negedge clk); chk("R10 irq enabled", irq, 1);
    wr(A_IEN, 16'h0001); @(negedge clk); chk("R10 irq masked", irq, 0);

    // R8 capture: ch0 rising, ch1 falling, ch2 both
    wr(A_FLAG, 16'h01FF);
    wr(A_ICEDGE, 16'h0039);
    @(negedge clk); icp = 3'b111;
    @(negedge clk);
    rd(A_COUNT, c);
    repeat (4) @(negedge clk);
    rd(A_FLAG, v);       chk("R8 rise flags", v & 16'h01C0, 16'h0140);
    rd(A_CAP0, v);       chk("R8 rise capture ch0", v, c);
    rd(A_CAP0 + 2, v);   chk("R8 rise capture ch2", v, c);
    wr(A_FLAG, 16'h01FF);
    @(negedge clk); icp = 3'b000;
    @(negedge clk);
    rd(A_COUNT, c2);
    repeat (4) @(negedge clk);
    rd(A_FLAG, v);       chk("R8 fall flags", v & 16'h01C0, 16'h0180);
    rd(A_CAP0 + 1, v);   chk("R8 fall capture ch1", v, c2);
    rd(A_CAP0, v);       chk("R8 ch0 ignores fall", v, c);

    // R4 rollover at divide by 1
    wr(A_FLAG, 16'h01FF);
    rd(A_FLAG, v); chk("R4 no rollover yet", v[0], 0);
    rd(A_COUNT, c);
    repeat (65541 - int'(c)) @(negedge clk);
    rd(A_FLAG, v); chk("R4 rollover flag", v[0], 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule